// File: doc/BRIEF.md
# Half-Band Rate-Changing FIR Filter

This block is a fixed-coefficient low-pass FIR filter with 55 taps. Its coefficients are symmetric, so its phase response is linear. It has the half-band shape: the centre weight is one half, and every second weight on either side of the centre is zero. The filter can run at equal rate, halve the sample rate (2:1 decimation) or double it (1:2 interpolation). All three modes use one master clock.

When interpolating, the block takes a new input word on every second clock and feeds zeros into the delay line on the clocks in between. It produces a result on every clock. When decimating, it takes a word on every clock and flags every second result as valid. A single falling edge on the `align` strobe sets which clock is the "first" phase. The full-precision accumulator result comes out unrounded, together with a valid flag. Rounding and output formatting are left to a later stage.

Top module: `hb_rate_fir`

## Requirements
- R1: `dout` after clock edge e+m holds the sum over j of h(j)·x(e+m−7−j), where x(t) is the sample that entered the delay line at edge t. An impulse of amplitude A therefore gives output samples from edge e+7 to edge e+61, with its peak A·h(27) at edge e+34. All other outputs are zero.
- R2: The weights are h(j)=h(54−j), built from a 28-entry parameter array. The centre weight h(27) is 16384, which is 0.5 in a 16-bit format with 15 fraction bits. h(j) is zero when 27−j is even and nonzero.
- R3: With `rsel`=2'b01 (decimate), `din` is taken on every clock. `dout_valid` is high on alternate clocks only, marking the results whose newest sample arrived on a phase-0 clock.
- R4: With `rsel`=2'b10 (interpolate, −6 dB), `din` is taken only on phase-0 clocks and a zero is inserted on phase-1 clocks. `dout_valid` is high on every clock and no extra gain is applied.
- R5: With `UNITY_INTERP`=1 and `rsel`=2'b00, the block interpolates as in R4 and doubles the result for each sample that entered in this mode.
- R6: `rsel`=2'b11 always selects equal rate. `rsel`=2'b00 also selects equal rate when `UNITY_INTERP`=0. Equal rate takes every input and marks every result valid.
- R7: If `align` was high on the previous clock and is low on the current one, the current clock is phase 0. Otherwise the phase alternates on every clock.
- R8: In equal-rate mode, `align` has no effect on `dout` or `dout_valid`.
- R9: Holding `align` low, or toggling it at half the clock rate in step with the phase, gives the same output as a single alignment pulse.
- R10: A synchronous `rst` clears the delay line and pipeline, so `dout`=0 and `dout_valid`=0. The first clock after reset is phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rsel | input | 2 | Mode select: 01 decimate, 10 interpolate −6 dB, 11 equal rate, 00 equal rate or unity-gain interpolate |
| align | input | 1 | Phase alignment strobe; a high-to-low step marks phase 0 |
| din | input | 12 | Two's-complement input sample, bit 11 is the sign |
| dout | output | 35 | Full-precision signed filter result |
| dout_valid | output | 1 | Result on `dout` belongs to the output sample stream |

## Verification
The bench drives an impulse and checks the exact arrival clock of the first output, the peak and the last output. A pipeline that is one stage short or long would put every one of these samples off by a clock. The bench also checks the zero weights at even distances from the centre, and the mirror symmetry of the response, so a wrongly paired pre-add shows up. It re-aligns the phase mid-stream, both with single pulses and with a half-rate `align` toggle. A design that counted its phase from the rising edge of `align`, or that ignored re-alignment, would flag the wrong decimated outputs and stuff zeros into the wrong slots. Finally, it runs code 00 on both parameter variants side by side. A design that doubled the result in the −6 dB mode, or interpolated when `UNITY_INTERP`=0, would show a factor-of-two or rate mismatch on every clock.

// File: rtl/hb_rate_fir.sv
module hb_rate_fir #(
  parameter int DW = 12,
  parameter int CW = 16,
  parameter int NTAP = 55,
  parameter int PAD = 4,
  parameter bit UNITY_INTERP = 1'b0,
  parameter int OW = DW + CW + 7,
  parameter logic signed [CW-1:0] COEF [0:(NTAP+1)/2-1] = '{
    -16'sd8,    16'sd0,  16'sd20,   16'sd0, -16'sd40,   16'sd0,  16'sd70,
      16'sd0, -16'sd115,  16'sd0,  16'sd180,  16'sd0, -16'sd270,  16'sd0,
     16'sd400,  16'sd0, -16'sd580,  16'sd0,  16'sd840,  16'sd0, -16'sd1230,
      16'sd0,  16'sd1900,  16'sd0, -16'sd3340, 16'sd0, 16'sd10280, 16'sd16384}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           rsel,
  input  logic                 align,
  input  logic signed [DW-1:0] din,
  output logic signed [OW-1:0] dout,
  output logic                 dout_valid
);
  localparam int NU   = (NTAP + 1) / 2;
  localparam int CTR  = NU - 1;
  localparam int PW   = DW + 1 + CW;
  localparam int AW   = OW - 1;
  localparam int VL   = PAD + 4;
  localparam int CNTW = $clog2(VL + 1);

  wire is_dec = (rsel == 2'b01);
  wire is_dbl = (rsel == 2'b00) && UNITY_INTERP;
  wire is_int = (rsel == 2'b10) || is_dbl;

  logic sync_d, ph_q;
  wire resync = sync_d & ~align;
  wire p0 = resync | ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d <= 1'b0;
      ph_q   <= 1'b1;
    end else begin
      sync_d <= align;
      ph_q   <= ~p0;
    end
  end

  wire signed [DW-1:0] x_in = (is_int && !p0) ? '0 : din;

  logic signed [DW-1:0] tap [0:NTAP-1];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) tap[i] <= '0;
    end else begin
      tap[0] <= x_in;
      for (int i = 1; i < NTAP; i++) tap[i] <= tap[i-1];
    end
  end

  for (genvar k = 0; k < NU; k++) begin : g_t
    logic signed [PW-1:0] p;
    logic signed [AW-1:0] run;
    if (k != CTR && ((CTR - k) % 2) == 0) begin : g_z
      assign p = '0;
    end else begin : g_m
      logic signed [DW:0] pre;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre <= '0;
          p   <= '0;
        end else begin
          if (k == CTR) pre <= {tap[k][DW-1], tap[k]};
          else          pre <= {tap[k][DW-1], tap[k]} + {tap[NTAP-1-k][DW-1], tap[NTAP-1-k]};
          p <= pre * COEF[k];
        end
      end
    end
    if (k == 0) begin : g_f
      assign run = AW'(p);
    end else begin : g_n
      assign run = g_t[k-1].run + AW'(p);
    end
  end

  logic [2:0] dbl_p;
  logic [VL-1:0] vld_p;
  logic signed [OW-1:0] sum_q;
  logic signed [OW-1:0] pad_q [0:PAD-1];
  wire signed [AW-1:0] acc = g_t[NU-1].run;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbl_p <= '0;
      vld_p <= '0;
      sum_q <= '0;
      for (int i = 0; i < PAD; i++) pad_q[i] <= '0;
    end else begin
      dbl_p <= {dbl_p[1:0], is_dbl};
      vld_p <= {vld_p[VL-2:0], (is_dec ? p0 : 1'b1)};
      sum_q <= dbl_p[2] ? (OW'(acc) <<< 1) : OW'(acc);
      pad_q[0] <= sum_q;
      for (int i = 1; i < PAD; i++) pad_q[i] <= pad_q[i-1];
    end
  end

  assign dout = pad_q[PAD-1];
  assign dout_valid = vld_p[VL-1];

  logic [CNTW-1:0] nd_cnt;
  always_ff @(posedge clk) begin
    if (rst) nd_cnt <= '0;
    else if (is_dec) nd_cnt <= '0;
    else if (nd_cnt != CNTW'(VL)) nd_cnt <= nd_cnt + 1'b1;
  end

  a_r4_zero_slot: assert property (@(posedge clk) disable iff (rst)
    (is_int && !p0) |=> (tap[0] == '0));
  a_r3_dec_every_input: assert property (@(posedge clk) disable iff (rst)
    is_dec |=> (tap[0] == $past(din)));
  a_r7_resync_phase: assert property (@(posedge clk) disable iff (rst)
    (sync_d && !align) |=> !ph_q);
  a_r6_full_rate_valid: assert property (@(posedge clk) disable iff (rst)
    (nd_cnt == CNTW'(VL)) |-> dout_valid);
  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dout_valid && dout == '0));
endmodule

// File: tb/hb_rate_fir_tb_top.sv
module hb_rate_fir_ref #(parameter bit UNITY = 1'b0) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rsel,
  input  logic              align,
  input  logic signed [11:0] din,
  output longint            exp_dout,
  output bit                exp_valid
);
  longint h [0:54];
  longint hist [0:54];
  longint qd [$];
  bit qv [$];
  bit sprev, ph, p0, dec, dbl, intp;
  longint y;

  initial begin
    longint c [0:27];
    c = '{-8, 0, 20, 0, -40, 0, 70, 0, -115, 0, 180, 0, -270, 0,
          400, 0, -580, 0, 840, 0, -1230, 0, 1900, 0, -3340, 0, 10280, 16384};
    for (int j = 0; j < 55; j++) h[j] = (j <= 27) ? c[j] : c[54-j];
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < 55; j++) hist[j] = 0;
      qd.delete();
      qv.delete();
      for (int j = 0; j < 7; j++) begin qd.push_back(0); qv.push_back(1'b0); end
      sprev = 1'b0;
      ph = 1'b1;
      exp_dout <= 0;
      exp_valid <= 1'b0;
    end else begin
      dec  = (rsel == 2'b01);
      dbl  = (rsel == 2'b00) && UNITY;
      intp = (rsel == 2'b10) || dbl;
      p0 = (sprev && !align) ? 1'b1 : ph;
      ph = !p0;
      sprev = align;
      for (int j = 54; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = (intp && !p0) ? 0 : longint'(din);
      y = 0;
      for (int j = 0; j < 55; j++) y += h[j] * hist[j];
      if (dbl) y = 2 * y;
      qd.push_back(y);
      qv.push_back(dec ? p0 : 1'b1);
      exp_dout <= qd.pop_front();
      exp_valid <= qv.pop_front();
    end
  end
endmodule

module hb_rate_fir_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rsel = 2'b11;
  logic align = 1'b0;
  logic signed [11:0] din = '0;
  logic signed [34:0] dout_i, dout_u;
  logic valid_i, valid_u;
  longint ei_d, eu_d;
  bit ei_v, eu_v;
  int compared = 0;
  int mismatched = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string lab_i = "R10";
  string lab_u = "R10";
  longint resp [0:63];
  bit vv [0:9];
  int cnt;

  always #4 clk = ~clk;

  hb_rate_fir dut_i (.clk(clk), .rst(rst), .rsel(rsel), .align(align), .din(din),
                     .dout(dout_i), .dout_valid(valid_i));
  hb_rate_fir #(.UNITY_INTERP(1'b1)) dut_u (.clk(clk), .rst(rst), .rsel(rsel), .align(align),
                     .din(din), .dout(dout_u), .dout_valid(valid_u));
  hb_rate_fir_ref #(.UNITY(1'b0)) ref_i (.clk(clk), .rst(rst), .rsel(rsel), .align(align),
                     .din(din), .exp_dout(ei_d), .exp_valid(ei_v));
  hb_rate_fir_ref #(.UNITY(1'b1)) ref_u (.clk(clk), .rst(rst), .rsel(rsel), .align(align),
                     .din(din), .exp_dout(eu_d), .exp_valid(eu_v));

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (chk_en && !rst) begin
      chk(lab_i, longint'(dout_i), ei_d);
      chk(lab_i, longint'(valid_i), longint'(ei_v));
      chk(lab_u, longint'(dout_u), eu_d);
      chk(lab_u, longint'(valid_u), longint'(eu_v));
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    @(negedge clk);
    chk("R10", longint'(dout_i), 0);
    chk("R10", longint'(valid_i), 0);
    rst = 1'b0;
    step();
    @(negedge clk);
    chk("R10", longint'(dout_i), 0);
    chk("R10", longint'(valid_u), 0);
    chk_en = 1'b1;

    // equal rate impulse: latency, peak, symmetry and zero taps
    lab_i = "R1"; lab_u = "R1";
    repeat (5) step();
    din = 12'sd1000;
    step();
    din = '0;
    for (int m = 0; m < 64; m++) begin
      @(negedge clk);
      resp[m] = longint'(dout_i);
    end
    chk("R1", resp[6], 0);
    chk("R1", resp[7], -8000);
    chk("R1", resp[34], 16384000);
    chk("R1", resp[61], -8000);
    chk("R1", resp[62], 0);
    chk("R2", resp[32], 0);
    chk("R2", resp[33], resp[35]);
    chk("R2", resp[20], resp[48]);
    chk("R2", resp[33], 10280000);

    // equal rate with align thrashing
    lab_i = "R8"; lab_u = "R8";
    step();
    cnt = 0;
    for (int n = 0; n < 40; n++) begin
      align = 1'($urandom_range(0, 1));
      din = 12'($urandom_range(0, 4095));
      step();
      @(negedge clk);
      if (valid_i) cnt++;
    end
    chk("R8", cnt, 40);
    align = 1'b0;

    // code 00 on both variants
    lab_i = "R6"; lab_u = "R5";
    rsel = 2'b00;
    repeat (10) step();
    cnt = 0;
    for (int n = 0; n < 40; n++) begin
      din = 12'($urandom_range(0, 4095));
      step();
      @(negedge clk);
      if (valid_i) cnt++;
    end
    chk("R6", cnt, 40);
    din = 12'sd500;
    align = 1'b1;
    step();
    align = 1'b0;
    repeat (30) begin din = 12'($urandom_range(0, 4095)); step(); end

    // decimate, single alignment pulse
    lab_i = "R7"; lab_u = "R7";
    rsel = 2'b01;
    repeat (20) begin din = 12'($urandom_range(0, 4095)); step(); end
    align = 1'b1;
    step();
    align = 1'b0;
    din = 12'sd77;
    step();
    for (int m = 0; m < 10; m++) begin
      @(negedge clk);
      vv[m] = valid_i;
    end
    chk("R7", longint'(vv[7]), 1);
    chk("R7", longint'(vv[8]), 0);
    chk("R7", longint'(vv[9]), 1);
    lab_i = "R3"; lab_u = "R3";
    step();
    cnt = 0;
    for (int n = 0; n < 40; n++) begin
      din = 12'($urandom_range(0, 4095));
      step();
      @(negedge clk);
      if (valid_i) cnt++;
    end
    chk("R3", cnt, 20);

    // decimate, half-rate toggle then re-align on the other phase
    lab_i = "R9"; lab_u = "R9";
    for (int n = 0; n < 30; n++) begin
      align = ~align;
      din = 12'($urandom_range(0, 4095));
      step();
    end
    lab_i = "R7"; lab_u = "R7";
    align = 1'b0;
    step();
    align = 1'b1;
    step();
    align = 1'b0;
    repeat (20) begin din = 12'($urandom_range(0, 4095)); step(); end

    // interpolate at -6 dB
    lab_i = "R4"; lab_u = "R4";
    rsel = 2'b10;
    align = 1'b1;
    step();
    align = 1'b0;
    repeat (10) begin din = 12'($urandom_range(0, 4095)); step(); end
    cnt = 0;
    for (int n = 0; n < 40; n++) begin
      din = 12'($urandom_range(0, 4095));
      step();
      @(negedge clk);
      if (valid_i) cnt++;
    end
    chk("R4", cnt, 40);
    lab_i = "R9"; lab_u = "R9";
    for (int n = 0; n < 30; n++) begin
      align = ~align;
      din = 12'($urandom_range(0, 4095));
      step();
    end
    align = 1'b0;

    // full-scale extremes at equal rate
    lab_i = "R1"; lab_u = "R1";
    rsel = 2'b11;
    for (int n = 0; n < 40; n++) begin
      din = (n % 2 == 0) ? 12'sh7FF : 12'sh800;
      step();
    end
    din = '0;
    repeat (70) step();

    done = 1'b1;
    chk_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule